// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This block moves a system between four power modes: SLEEP, DOZE, SLOW and NORMAL. Software asks for a mode through three control bits in a small register. The block then walks a state machine that starts the crystal oscillator or the PLL, waits for a ready indication from each, and only then moves the clocks to the new source. Interrupt requests wake the system from SLEEP. A wait-for-interrupt indication from the processor allows the system to drop back into SLEEP.

The block drives two clock-source select outputs. One is for the system clocks and one is for the controller's own clock. It also drives enable lines to the crystal-oscillator and PLL start-up logic, and takes a ready input back from each. Each mode change passes through a named transition state. A start-up that never reports ready is abandoned after a programmable number of cycles. When that happens, the block returns to the mode it came from and records the failure in a sticky flag.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the state is DOZE (code 1) and the mode bits read 3'b001. Both clock selects are low-speed oscillator (code 1). Both enables are low, the error flag is clear, and the timeout limit reads back the TMO_RESET parameter (default 64).
- R2: In SLEEP (code 0) the system clock select is OFF (code 0) and the controller clock select is low-speed oscillator (code 1).
- R3: In SLEEP, either interrupt input moves the state to DOZE on the next clock. On the same edge the mode bits are rewritten to 3'b001. A register write in that same cycle is discarded.
- R4: DOZE goes to SLEEP only when all three mode bits are zero and cpuWfi is high. Otherwise it stays in DOZE unless a SLOW or NORMAL request is pending.
- R5: In DOZE, a set SLOW bit (bit 1) or NORMAL bit (bit 2) enters the crystal start-up state (code 4) with xtalEn high. xtalReady then moves the state to SLOW (code 2), where both selects become crystal (code 2).
- R6: In SLOW with the NORMAL bit set, the state enters PLL start-up (code 5). pllReady then moves it to NORMAL (code 3), where both selects are PLL (code 3) and both xtalEn and pllEn are high.
- R7: In NORMAL, clearing the NORMAL bit enters the leave-PLL state (code 6) for one cycle. That state lands in SLOW if the SLOW bit is set, otherwise in DOZE.
- R8: In SLOW, with neither SLOW nor NORMAL set, the state enters the leave-crystal state (code 7) for one cycle and then DOZE, where xtalEn is low.
- R9: A start-up state lasts limit+1 cycles without a ready indication and then times out. On timeout the state returns to the previous steady mode: crystal start-up returns to DOZE with mode bits 3'b001, and PLL start-up returns to SLOW with mode bits 3'b010. The error flag is set and stays set until reset. A ready input in the same cycle as the timeout wins.
- R10: The clock selects change only on the edge where the state enters a steady mode. Through every transition state they hold the values of the last steady mode.
- R11: Register map. At address 0, a write sets the mode bits from data[2:0]. A read of address 0 returns mode bits in [2:0], the state code in [5:3] and the error flag in [6]. Address 1 writes and reads the timeout limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 control/status, 1 timeout limit |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data (combinational) |
| intReq | input | 1 | Normal interrupt request |
| fastIntReq | input | 1 | Fast interrupt request |
| cpuWfi | input | 1 | Processor is waiting for an interrupt |
| xtalReady | input | 1 | Crystal oscillator is stable |
| pllReady | input | 1 | PLL is locked |
| xtalEn | output | 1 | Crystal oscillator enable |
| pllEn | output | 1 | PLL enable |
| sysClkSel | output | 2 | System clock source: 0 off, 1 low-speed, 2 crystal, 3 PLL |
| ctlClkSel | output | 2 | Controller clock source, same encoding |

## Verification
The bench writes a register in the same cycle as a wake-up interrupt. A design that lets the software write win would wake with the wrong mode bits and jump straight into a start-up sequence. The bench holds the ready inputs low through start-up and checks that the clock selects keep their old value. A design that switches the selects on entering a transition state would move a clock onto an oscillator that has not settled. Timeouts are exercised for both crystal and PLL, and the bench counts the cycles spent in start-up. An off-by-one in the counter, or a failure to rewrite the mode bits, shows up as a wrong dwell count or as an endless retry loop. The bench also clears all mode bits while the processor is not in wait-for-interrupt, which catches a design that sleeps too early.

// File: rtl/pwr_mode_pkg.sv
`timescale 1ns/1ps
package pwr_mode_pkg;

  localparam int MODE_W     = 3;
  localparam int BIT_DOZE   = 0;
  localparam int BIT_SLOW   = 1;
  localparam int BIT_NORMAL = 2;

  typedef enum logic [2:0] {
    ST_SLEEP      = 3'd0,
    ST_DOZE       = 3'd1,
    ST_SLOW       = 3'd2,
    ST_NORMAL     = 3'd3,
    ST_XTAL_UP    = 3'd4,
    ST_PLL_UP     = 3'd5,
    ST_LEAVE_PLL  = 3'd6,
    ST_LEAVE_XTAL = 3'd7
  } pwrState_t;

  typedef enum logic [1:0] {
    CK_OFF    = 2'd0,
    CK_LOWOSC = 2'd1,
    CK_XTAL   = 2'd2,
    CK_PLL    = 2'd3
  } clkSrc_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic              cntRun;
    logic              errSet;
    logic              bitsForce;
    logic [MODE_W-1:0] bitsVal;
    logic              selLoad;
    clkSrc_t           selSys;
    clkSrc_t           selCtl;
  } ctlStrobe_t;

  function automatic logic isSteady(pwrState_t s);
    return (s == ST_SLEEP) || (s == ST_DOZE) || (s == ST_SLOW) || (s == ST_NORMAL);
  endfunction

endpackage

// File: rtl/pwr_mode_ctrl.sv
`timescale 1ns/1ps
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeBits,
  input  logic              intReq,
  input  logic              fastIntReq,
  input  logic              cpuWfi,
  input  logic              xtalReady,
  input  logic              pllReady,
  input  logic              timedOut,
  output pwrState_t         state,
  output ctlStrobe_t        stb,
  output logic              xtalEn,
  output logic              pllEn
);

  pwrState_t nextState;
  logic      wake;
  logic      tmoTaken;
  logic      wantFast;

  assign wake     = intReq || fastIntReq;
  assign wantFast = modeBits[BIT_SLOW] || modeBits[BIT_NORMAL];

  always_comb begin
    nextState = state;
    tmoTaken  = 1'b0;
    case (state)
      ST_SLEEP: if (wake) nextState = ST_DOZE;
      ST_DOZE: begin
        if (wantFast) nextState = ST_XTAL_UP;
        else if (modeBits == '0 && cpuWfi) nextState = ST_SLEEP;
      end
      ST_XTAL_UP: begin
        if (xtalReady) nextState = ST_SLOW;
        else if (timedOut) begin
          nextState = ST_DOZE;
          tmoTaken  = 1'b1;
        end
      end
      ST_SLOW: begin
        if (modeBits[BIT_NORMAL]) nextState = ST_PLL_UP;
        else if (!modeBits[BIT_SLOW]) nextState = ST_LEAVE_XTAL;
      end
      ST_PLL_UP: begin
        if (pllReady) nextState = ST_NORMAL;
        else if (timedOut) begin
          nextState = ST_SLOW;
          tmoTaken  = 1'b1;
        end
      end
      ST_NORMAL:     if (!modeBits[BIT_NORMAL]) nextState = ST_LEAVE_PLL;
      ST_LEAVE_PLL:  nextState = modeBits[BIT_SLOW] ? ST_SLOW : ST_DOZE;
      ST_LEAVE_XTAL: nextState = ST_DOZE;
      default:       nextState = ST_DOZE;
    endcase
  end

  always_comb begin
    stb           = '0;
    stb.cntRun    = (state == ST_XTAL_UP) || (state == ST_PLL_UP);
    stb.errSet    = tmoTaken;
    stb.selLoad   = (nextState != state) && isSteady(nextState);
    stb.selSys    = CK_LOWOSC;
    stb.selCtl    = CK_LOWOSC;
    case (nextState)
      ST_SLEEP:  stb.selSys = CK_OFF;
      ST_SLOW:   begin stb.selSys = CK_XTAL; stb.selCtl = CK_XTAL; end
      ST_NORMAL: begin stb.selSys = CK_PLL;  stb.selCtl = CK_PLL;  end
      default:   ;
    endcase
    if (state == ST_SLEEP && wake) begin
      stb.bitsForce = 1'b1;
      stb.bitsVal   = MODE_W'(1) << BIT_DOZE;
    end else if (tmoTaken) begin
      stb.bitsForce = 1'b1;
      stb.bitsVal   = (state == ST_PLL_UP) ? (MODE_W'(1) << BIT_SLOW)
                                           : (MODE_W'(1) << BIT_DOZE);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_DOZE;
      xtalEn <= 1'b0;
      pllEn  <= 1'b0;
    end else begin
      state  <= nextState;
      xtalEn <= (nextState != ST_SLEEP) && (nextState != ST_DOZE);
      pllEn  <= (nextState == ST_PLL_UP) || (nextState == ST_NORMAL) ||
                (nextState == ST_LEAVE_PLL);
    end
  end

  AST_WAKE_TO_DOZE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLEEP && wake) |=> (state == ST_DOZE && modeBits == 3'b001)); // R3
  AST_SLEEP_NEEDS_WFI: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DOZE && !(cpuWfi && modeBits == '0)) |=> (state != ST_SLEEP)); // R4
  AST_NORMAL_ENABLES: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_NORMAL) |-> (pllEn && xtalEn)); // R6
  AST_LEAVE_XTAL_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LEAVE_XTAL) |=> (state == ST_DOZE)); // R8

endmodule

// File: rtl/pwr_mode_dp.sv
`timescale 1ns/1ps
module pwr_mode_dp
  import pwr_mode_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 16,
  parameter int TMO_RESET = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  ctlStrobe_t        stb,
  input  pwrState_t         state,
  output logic [MODE_W-1:0] modeBits,
  output logic              timedOut,
  output logic              errFlag,
  output clkSrc_t           sysClkSel,
  output clkSrc_t           ctlClkSel
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam int               ERR_POS  = 2 * MODE_W;
  localparam int               ST_LO    = MODE_W;

  logic [CNT_W-1:0] tmoLimit;
  logic [CNT_W-1:0] tmoCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeBits <= MODE_W'(1) << BIT_DOZE;
      tmoLimit <= CNT_W'(TMO_RESET);
    end else begin
      if (stb.bitsForce) modeBits <= stb.bitsVal;
      else if (regWrEn && !regAddr) modeBits <= regWrData[MODE_W-1:0];
      if (regWrEn && regAddr) tmoLimit <= regWrData[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !stb.cntRun) tmoCnt <= '0;
    else if (tmoCnt != CNT_MAX) tmoCnt <= tmoCnt + 1'b1;
  end

  assign timedOut = stb.cntRun && (tmoCnt >= tmoLimit);

  always_ff @(posedge clk) begin
    if (!rstN) errFlag <= 1'b0;
    else if (stb.errSet) errFlag <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sysClkSel <= CK_LOWOSC;
      ctlClkSel <= CK_LOWOSC;
    end else if (stb.selLoad) begin
      sysClkSel <= stb.selSys;
      ctlClkSel <= stb.selCtl;
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr) begin
      regRdData[CNT_W-1:0] = tmoLimit;
    end else begin
      regRdData[MODE_W-1:0]     = modeBits;
      regRdData[ST_LO +: 3]     = state;
      regRdData[ERR_POS]        = errFlag;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag); // R9
  AST_SLEEP_CLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLEEP) |-> (sysClkSel == CK_OFF && ctlClkSel == CK_LOWOSC)); // R2

endmodule

// File: rtl/pwr_mode_seq.sv
`timescale 1ns/1ps
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 16,
  parameter int TMO_RESET = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              intReq,
  input  logic              fastIntReq,
  input  logic              cpuWfi,
  input  logic              xtalReady,
  input  logic              pllReady,
  output logic              xtalEn,
  output logic              pllEn,
  output logic [1:0]        sysClkSel,
  output logic [1:0]        ctlClkSel
);

  pwrState_t         state;
  ctlStrobe_t        stb;
  logic [MODE_W-1:0] modeBits;
  logic              timedOut;
  logic              errFlag;
  clkSrc_t           sysSel;
  clkSrc_t           ctlSel;
  logic              inTransit;

  pwr_mode_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .modeBits(modeBits), .intReq(intReq),
    .fastIntReq(fastIntReq), .cpuWfi(cpuWfi), .xtalReady(xtalReady),
    .pllReady(pllReady), .timedOut(timedOut), .state(state), .stb(stb),
    .xtalEn(xtalEn), .pllEn(pllEn)
  );

  pwr_mode_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W), .TMO_RESET(TMO_RESET)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .stb(stb), .state(state),
    .modeBits(modeBits), .timedOut(timedOut), .errFlag(errFlag),
    .sysClkSel(sysSel), .ctlClkSel(ctlSel)
  );

  assign sysClkSel = sysSel;
  assign ctlClkSel = ctlSel;
  assign inTransit = !isSteady(state);

  AST_SEL_HOLD_IN_TRANSIT: assert property (@(posedge clk) disable iff (!rstN)
    inTransit |=> (!inTransit || ($stable(sysClkSel) && $stable(ctlClkSel)))); // R10
  AST_SEL_MOVES_ON_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sysClkSel)) |-> (!inTransit && state != $past(state))); // R10

endmodule

// File: tb/pwr_mode_seq_tb.sv
`timescale 1ns/1ps
module pwr_mode_seq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regAddr = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        intReq = 1'b0, fastIntReq = 1'b0, cpuWfi = 1'b0;
  logic        xtalReady = 1'b0, pllReady = 1'b0;
  logic        xtalEn, pllEn;
  logic [1:0]  sysClkSel, ctlClkSel;

  int nChecks = 0;
  int nFail   = 0;

  always #2 clk = ~clk;

  pwr_mode_seq u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .intReq(intReq),
    .fastIntReq(fastIntReq), .cpuWfi(cpuWfi), .xtalReady(xtalReady),
    .pllReady(pllReady), .xtalEn(xtalEn), .pllEn(pllEn),
    .sysClkSel(sysClkSel), .ctlClkSel(ctlClkSel)
  );

  // {mode bits, expected state, expected clock select}
  localparam logic [7:0] VEC [10] = '{
    {3'b010, 3'd2, 2'd2}, {3'b110, 3'd3, 2'd3}, {3'b010, 3'd2, 2'd2},
    {3'b100, 3'd3, 2'd3}, {3'b000, 3'd1, 2'd1}, {3'b100, 3'd3, 2'd3},
    {3'b011, 3'd2, 2'd2}, {3'b001, 3'd1, 2'd1}, {3'b101, 3'd3, 2'd3},
    {3'b001, 3'd1, 2'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wrReg(input logic a, input logic [15:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    step(1);
    regWrEn = 1'b0; regAddr = 1'b0;
  endtask

  function automatic logic [2:0] stNow();
    return regRdData[5:3];
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 status", regRdData, 16'h0009);
    chk("R1 sysSel", sysClkSel, 1);
    chk("R1 ctlSel", ctlClkSel, 1);
    chk("R1 enables", {xtalEn, pllEn}, 0);
    regAddr = 1'b1; #0.1;
    chk("R1 limit", regRdData, 64);
    regAddr = 1'b0;

    // table walk: R5 R6 R7 R8 with both oscillators ready
    xtalReady = 1'b1; pllReady = 1'b1;
    for (int v = 0; v < 10; v++) begin
      wrReg(1'b0, {13'd0, VEC[v][7:5]});
      step(8);
      chk("R5-8 table state", stNow(), VEC[v][4:2]);
      chk("R7 table sysSel", sysClkSel, VEC[v][1:0]);
      chk("R6 table ctlSel", ctlClkSel, VEC[v][1:0]);
      chk("R8 table xtalEn", xtalEn, VEC[v][4:2] != 3'd1);
      chk("R6 table pllEn", pllEn, VEC[v][4:2] == 3'd3);
    end
    xtalReady = 1'b0; pllReady = 1'b0;

    // R4: bits clear but no wfi keeps DOZE
    wrReg(1'b0, 16'd0);
    step(4);
    chk("R4 no wfi stays DOZE", stNow(), 1);
    cpuWfi = 1'b1;
    step(1);
    chk("R4 wfi enters SLEEP", stNow(), 0);
    cpuWfi = 1'b0;
    chk("R2 sleep sysSel", sysClkSel, 0);
    chk("R2 sleep ctlSel", ctlClkSel, 1);
    step(3);
    chk("R3 no irq stays SLEEP", stNow(), 0);
    // R3 wake with colliding write
    fastIntReq = 1'b1; regWrEn = 1'b1; regWrData = 16'h0006;
    step(1);
    fastIntReq = 1'b0; regWrEn = 1'b0;
    chk("R3 wake state", stNow(), 1);
    chk("R3 wake bits", regRdData[2:0], 3'b001);
    step(4);
    chk("R3 write discarded", stNow(), 1);
    // normal interrupt path
    wrReg(1'b0, 16'd0);
    cpuWfi = 1'b1; step(1); cpuWfi = 1'b0;
    chk("R4 sleep again", stNow(), 0);
    intReq = 1'b1; step(1); intReq = 1'b0;
    chk("R3 irq wake", regRdData[5:0], {3'd1, 3'b001});

    // R10 selects hold during start-up
    wrReg(1'b0, 16'h0002);
    step(1);
    chk("R5 crystal start state", stNow(), 4);
    chk("R5 xtalEn in start", xtalEn, 1);
    step(3);
    chk("R10 sysSel held", sysClkSel, 1);
    chk("R10 ctlSel held", ctlClkSel, 1);
    xtalReady = 1'b1;
    step(1);
    chk("R10 sysSel on entry", sysClkSel, 2);
    chk("R5 slow reached", stNow(), 2);
    wrReg(1'b0, 16'h0001);
    step(1);
    chk("R8 leave crystal", stNow(), 7);
    chk("R10 sel held leaving", sysClkSel, 2);
    step(1);
    chk("R8 lands DOZE", stNow(), 1);
    chk("R8 xtal off", xtalEn, 0);
    xtalReady = 1'b0;

    // R9 crystal timeout with limit 5
    wrReg(1'b1, 16'd5);
    regAddr = 1'b1; #0.1;
    chk("R11 limit readback", regRdData, 5);
    regAddr = 1'b0;
    wrReg(1'b0, 16'h0002);
    begin
      int dwell = 0;
      for (int i = 0; i < 30; i++) begin
        if (stNow() == 3'd4) dwell++;
        step(1);
      end
      chk("R9 start dwell", dwell, 6);
    end
    chk("R9 crystal timeout status", regRdData[6:0], {1'b1, 3'd1, 3'b001});
    // R9 PLL timeout
    xtalReady = 1'b1;
    wrReg(1'b0, 16'h0002);
    step(5);
    chk("R9 at SLOW", stNow(), 2);
    wrReg(1'b0, 16'h0006);
    step(20);
    chk("R9 PLL timeout status", regRdData[6:0], {1'b1, 3'd2, 3'b010});
    chk("R9 PLL off", pllEn, 0);
    chk("R10 sel kept crystal", sysClkSel, 2);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule